// File: doc/BRIEF.md
# Address-Keyed ROM Byte Descrambler

This block sits between a program ROM and an 8-bit CPU and undoes a fixed, address-dependent scrambling of the stored bytes. It receives the fetch address, the raw ROM byte and a flag that marks an opcode fetch, and it returns the plain byte within the same cycle. It has no clock and no state.

Two transforms are built in. The data transform serves operand and data reads. The opcode transform is a superset of the data transform and serves instruction fetches. Each transform first applies a set of bit inversions. Each inversion is enabled by a combination of address bits. Each transform then applies a sequence of conditional bit-pair swaps. The result depends on the order of these steps.

The opcode transform is used only when the opcode flag is high and the address falls inside a window set by parameters. The default window is 0x0000 to 0x1FFF. Every other access uses the data transform.

Top module: `rom_descrambler`

## Requirements
- R1: In both transforms, inversions are applied to the raw byte as follows. Bit 7 is inverted when A9=1 and A8=1. Bit 6 is inverted when A11=1, A4=1 and A1=1. Bit 2 is inverted when A11=1, A8=0 and A1=1. Bit 1 is inverted when A13=1, A6=0 and A4=1. Bit 0 is inverted when A11=0, A9=1 and A2=1. The data transform never alters bits 5 and 4.
- R2: The opcode transform adds three inversions. Bit 5 is inverted when A13=0 and A12=1. Bit 4 is inverted when A6=0 and A1=1. Bit 3 is inverted when A12=0 and A2=1.
- R3: In both transforms, after all inversions, bits 0 and 1 are exchanged when A13=1 and A4=1. Then bits 2 and 3 are exchanged when A8=1 and A4=1.
- R4: After those exchanges, the opcode transform exchanges bits 4 and 5 when A12=1 and A9=1. Last, it exchanges bits 6 and 7 when A11=1 and A6=0.
- R5: All swaps act on the byte that is already inverted, never on the raw byte. For example, a data read of 0x00 at 0x2010 gives 0x01.
- R6: The opcode transform is selected only when opfetch_i=1 and the address lies in [WIN_LO, WIN_HI] (default 0x0000 to 0x1FFF). Otherwise the data transform is used. For example, an opcode fetch of 0x00 at 0x4004 gives 0x00, not 0x08.
- R7: The output is a pure function of the present inputs. It follows an input change without any clock edge, and reset does not affect it.
- R8: When A1, A2, A4, A6, A8, A9, A11, A12 and A13 are all 0, the output equals the raw byte in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W (16) | CPU fetch address |
| raw_i | input | 8 | Byte as stored in ROM |
| opfetch_i | input | 1 | High on an instruction (opcode) fetch |
| data_o | output | 8 | Descrambled byte |

## Verification
The checker assertions are evaluated on every input change. They check four things: the swap stage keeps the number of set bits of the inverted byte; data reads, and opcode fetches outside the window, pass bits 5 and 4 through unchanged; addresses with no gating bits pass the byte through; and the opcode-only inversion of bit 3 appears whenever its condition holds and no swap moves that bit. Only the bench can show the exact bit positions and the order of the steps. It does this by comparing the output against an independent per-bit model over every address in both modes, over all 256 byte values at chosen addresses, and against worked vectors, including ones where a swap and an inversion act on the same bits.

// File: rtl/descr_pkg.sv
`timescale 1ns/1ps
package descr_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    XFORM_DATA   = 1'b0,
    XFORM_OPCODE = 1'b1
  } xform_e;
endpackage

// File: rtl/descr_invert.sv
`timescale 1ns/1ps
module descr_invert
  import descr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter xform_e      MODE   = XFORM_DATA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             raw_i,
  output byte_t             inv_o
);
  byte_t base_mask;
  byte_t extra_mask;

  always_comb begin
    base_mask    = '0;
    base_mask[7] = addr_i[9] & addr_i[8];
    base_mask[6] = addr_i[11] & addr_i[4] & addr_i[1];
    base_mask[2] = addr_i[11] & ~addr_i[8] & addr_i[1];
    base_mask[1] = addr_i[13] & ~addr_i[6] & addr_i[4];
    base_mask[0] = ~addr_i[11] & addr_i[9] & addr_i[2];
  end

  generate
    if (MODE == XFORM_OPCODE) begin : g_op_mask
      always_comb begin
        extra_mask    = '0;
        extra_mask[5] = ~addr_i[13] & addr_i[12];
        extra_mask[4] = ~addr_i[6] & addr_i[1];
        extra_mask[3] = ~addr_i[12] & addr_i[2];
      end
    end else begin : g_no_mask
      assign extra_mask = '0;
    end
  endgenerate

  assign inv_o = raw_i ^ base_mask ^ extra_mask;
endmodule

// File: rtl/descr_swap.sv
`timescale 1ns/1ps
module descr_swap
  import descr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter xform_e      MODE   = XFORM_DATA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             in_i,
  output byte_t             out_o
);
  byte_t s01, s23;

  // order matters: each stage consumes the previous stage's result
  always_comb begin
    s01 = in_i;
    if (addr_i[13] & addr_i[4]) s01[1:0] = {in_i[0], in_i[1]};
    s23 = s01;
    if (addr_i[8] & addr_i[4]) s23[3:2] = {s01[2], s01[3]};
  end

  generate
    if (MODE == XFORM_OPCODE) begin : g_op_swap
      byte_t s45, s67;
      always_comb begin
        s45 = s23;
        if (addr_i[12] & addr_i[9]) s45[5:4] = {s23[4], s23[5]};
        s67 = s45;
        if (addr_i[11] & ~addr_i[6]) s67[7:6] = {s45[6], s45[7]};
      end
      assign out_o = s67;
    end else begin : g_data_swap
      assign out_o = s23;
    end
  endgenerate
endmodule

// File: rtl/descr_window.sv
`timescale 1ns/1ps
module descr_window #(
  parameter int unsigned          ADDR_W = 16,
  parameter logic [ADDR_W-1:0]    WIN_LO = '0,
  parameter logic [ADDR_W-1:0]    WIN_HI = 16'h1FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o
);
  localparam logic [ADDR_W-1:0] SPAN = WIN_HI - WIN_LO;
  logic [ADDR_W-1:0] offset;

  assign offset   = addr_i - WIN_LO;
  assign in_win_o = (offset <= SPAN);
endmodule

// File: rtl/rom_descrambler.sv
`timescale 1ns/1ps
module rom_descrambler
  import descr_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = '0,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'h1FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        raw_i,
  input  logic              opfetch_i,
  output logic [7:0]        data_o
);
  localparam int unsigned NPATH = 2;

  byte_t inv_q   [NPATH];
  byte_t swp_q   [NPATH];
  logic  in_win;
  logic  use_op;

  generate
    for (genvar p = 0; p < NPATH; p++) begin : g_path
      localparam xform_e PMODE = (p == 0) ? XFORM_DATA : XFORM_OPCODE;
      descr_invert #(.ADDR_W(ADDR_W), .MODE(PMODE)) u_inv (
        .addr_i (addr_i),
        .raw_i  (raw_i),
        .inv_o  (inv_q[p])
      );
      descr_swap #(.ADDR_W(ADDR_W), .MODE(PMODE)) u_swp (
        .addr_i (addr_i),
        .in_i   (inv_q[p]),
        .out_o  (swp_q[p])
      );
    end
  endgenerate

  descr_window #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .addr_i   (addr_i),
    .in_win_o (in_win)
  );

  assign use_op = opfetch_i & in_win;
  assign data_o = use_op ? swp_q[1] : swp_q[0];
endmodule

// File: rtl/rom_descrambler_chk.sv
`timescale 1ns/1ps
module rom_descrambler_chk #(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = '0,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'h1FFF
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        raw_i,
  input logic              opfetch_i,
  input logic [7:0]        data_o,
  input logic [7:0]        inv_data,
  input logic [7:0]        inv_op,
  input logic              in_win
);
  logic known;
  logic sel_op;
  logic gate_zero;
  logic addr_inside;

  assign known       = !$isunknown({addr_i, raw_i, opfetch_i, data_o, inv_data, inv_op, in_win});
  assign sel_op      = opfetch_i & in_win;
  assign gate_zero   = ~|{addr_i[13:11], addr_i[9:8], addr_i[6], addr_i[4], addr_i[2:1]};
  assign addr_inside = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);

  always_comb begin
    if (known) begin
      p_swap_keeps_weight_r3: assert ($countones(data_o) == $countones(sel_op ? inv_op : inv_data))
        else $error("swap stage changed the bit count");
      p_data_mid_pass_r1: assert (sel_op || data_o[5:4] == raw_i[5:4])
        else $error("data transform touched bits 5:4");
      p_outside_window_data_r6: assert (!opfetch_i || addr_inside || data_o[5:4] == raw_i[5:4])
        else $error("opcode transform used outside window");
      p_plain_addr_pass_r8: assert (!gate_zero || data_o == raw_i)
        else $error("ungated address altered the byte");
      p_op_bit3_inv_r2: assert (!(sel_op && !addr_i[12] && addr_i[2] && !(addr_i[8] && addr_i[4]))
                                || data_o[3] != raw_i[3])
        else $error("opcode bit 3 inversion missing");
    end
  end
endmodule

bind rom_descrambler rom_descrambler_chk #(
  .ADDR_W (ADDR_W),
  .WIN_LO (WIN_LO),
  .WIN_HI (WIN_HI)
) u_chk (
  .addr_i    (addr_i),
  .raw_i     (raw_i),
  .opfetch_i (opfetch_i),
  .data_o    (data_o),
  .inv_data  (inv_q[0]),
  .inv_op    (inv_q[1]),
  .in_win    (in_win)
);

// File: tb/test_rom_descrambler.sv
`timescale 1ns/1ps
module test_rom_descrambler;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr;
  logic [7:0]  raw;
  logic        opf;
  logic [7:0]  dout;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rom_descrambler i_rom_descrambler (
    .addr_i    (addr),
    .raw_i     (raw),
    .opfetch_i (opf),
    .data_o    (dout)
  );

  // {opfetch, addr, raw, expected}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0000, 8'hA5, 8'hA5},  // R8
    {1'b1, 16'h0000, 8'h3C, 8'h3C},  // R8
    {1'b0, 16'h0300, 8'h00, 8'h80},  // R1
    {1'b1, 16'h0300, 8'h00, 8'h80},  // R1
    {1'b1, 16'h1000, 8'h00, 8'h20},  // R2
    {1'b0, 16'h1000, 8'h00, 8'h00},  // R1
    {1'b0, 16'h2010, 8'h00, 8'h01},  // R5
    {1'b1, 16'h2010, 8'h00, 8'h01},  // R6
    {1'b0, 16'h0110, 8'h04, 8'h08},  // R3
    {1'b1, 16'h1200, 8'h00, 8'h10},  // R4
    {1'b1, 16'h0800, 8'h40, 8'h80},  // R4
    {1'b1, 16'h0802, 8'h00, 8'h14},  // R2
    {1'b0, 16'h0802, 8'h00, 8'h04},  // R1
    {1'b1, 16'h0004, 8'h00, 8'h08},  // R2
    {1'b0, 16'h0004, 8'h00, 8'h00},  // R1
    {1'b1, 16'h4004, 8'h00, 8'h00}   // R6
  };

  function automatic logic [7:0] ref_model(input logic [15:0] a, input logic [7:0] b, input logic op);
    logic [7:0] v;
    logic       t;
    logic       opx;
    opx = op && (a <= 16'h1FFF);
    v = b;
    if (a[9] && a[8])               v[7] = !v[7];
    if (a[11] && a[4] && a[1])      v[6] = !v[6];
    if (a[11] && !a[8] && a[1])     v[2] = !v[2];
    if (a[13] && !a[6] && a[4])     v[1] = !v[1];
    if (!a[11] && a[9] && a[2])     v[0] = !v[0];
    if (opx && !a[13] && a[12])     v[5] = !v[5];
    if (opx && !a[6] && a[1])       v[4] = !v[4];
    if (opx && !a[12] && a[2])      v[3] = !v[3];
    if (a[13] && a[4])        begin t = v[0]; v[0] = v[1]; v[1] = t; end
    if (a[8] && a[4])         begin t = v[2]; v[2] = v[3]; v[3] = t; end
    if (opx && a[12] && a[9]) begin t = v[4]; v[4] = v[5]; v[5] = t; end
    if (opx && a[11] && !a[6]) begin t = v[6]; v[6] = v[7]; v[7] = t; end
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s addr=%h raw=%h op=%b actual=%h expected=%h", req, addr, raw, opf, dout, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [7:0] b, input logic op);
    addr = a; raw = b; opf = op;
    #0.01;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    addr = 16'h0000; raw = 8'h5A; opf = 1'b1;
    #2;
    check("R7", 8'h5A);  // combinational during reset
    apply(16'h0300, 8'h00, 1'b0);
    check("R7", 8'h80);  // follows inputs with reset held and no clock edge
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:16], VEC[i][15:8], VEC[i][32]);
      check("R1-vector", VEC[i][7:0]);
    end

    // full address sweep, both modes
    for (int a = 0; a < 65536; a++) begin
      for (int m = 0; m < 2; m++) begin
        apply(a[15:0], a[7:0] ^ a[15:8], m[0]);
        check("R1 R2 R3 R4 R6", ref_model(a[15:0], a[7:0] ^ a[15:8], m[0]));
        apply(a[15:0], ~a[7:0], m[0]);
        check("R5", ref_model(a[15:0], ~a[7:0], m[0]));
      end
    end

    // all byte values at addresses enabling every step
    for (int k = 0; k < 6; k++) begin
      logic [15:0] ka;
      case (k)
        0: ka = 16'h1B16;
        1: ka = 16'h2B12;
        2: ka = 16'h0A16;
        3: ka = 16'h1F96;
        4: ka = 16'h3316;
        default: ka = 16'h0000;
      endcase
      for (int b = 0; b < 256; b++) begin
        for (int m = 0; m < 2; m++) begin
          apply(ka, b[7:0], m[0]);
          check("R4", ref_model(ka, b[7:0], m[0]));
        end
      end
    end

    // window edges
    apply(16'h1FFF, 8'h00, 1'b1);
    check("R6", ref_model(16'h1FFF, 8'h00, 1'b1));
    apply(16'h2000, 8'h00, 1'b1);
    check("R6", ref_model(16'h2000, 8'h00, 1'b0));
    apply(16'h5002, 8'h00, 1'b1);
    check("R6", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule